// File: doc/BRIEF.md
# DMA Level-Request Acceptance Controller

This block serves one DMA channel whose transfer request comes from a peripheral as an active-low level. Once software enables the channel, the controller looks at the request pin on every rising clock edge. A low level seen while acceptance is open is held inside the controller as a pending request, and the controller raises a bus request. When the bus break arrives, the held request is cleared. The controller then runs one single-address transfer cycle, during which it drives an active-low acknowledge strobe to the requesting device.

The pin is ignored from the moment the held request is cleared until the transfer has finished. After the finish the bus goes back to other masters for a minimum release gap. Acceptance reopens as soon as the transfer completes, so a request seen during the gap is served once the gap ends. If the pin is held low, the channel runs back-to-back single transfers, each followed by the gap. Clearing the enable bit closes acceptance at once and drops a held request. A transfer that has already started still runs to its end.

Address generation, transfer counting, arbitration between channels and the data path are outside this block.

Top module: `dma_level_accept`

## Requirements
- R1: After reset, ack_n is 1, bus_req is 0, busy is 0 and the channel is disabled.
- R2: A cycle with en_wr=1 loads en_wdata into the channel enable bit on that clock edge. The request pin is first sampled on the following edge. A low level on the pin while the channel is disabled, including at the edge of the enabling write itself, is never held.
- R3: When req_n=0 is sampled in the idle state with the channel enabled, the request is held. From the next cycle bus_req=1 and busy=1, and both stay high until a bus break or a disabling write is sampled.
- R4: When bus_brk=1 is sampled while a request is held, the request is cleared (bus_req=0) and ack_n goes to 0 from the next cycle. ack_n stays 0 up to and including the cycle in which xfer_done=1 is sampled, and returns to 1 on the following cycle. ack_n is 1 at all other times.
- R5: From the request clear until the transfer completes, a low level on req_n is neither held nor acted on.
- R6: After a transfer completes, bus_req stays 0 for at least MIN_GAP cycles (default 2) before it can rise again.
- R7: Acceptance reopens on the first edge after the transfer completes. A low req_n sampled during the release gap is held and produces a new bus request once the gap has passed.
- R8: While req_n stays low and the channel stays enabled, the controller runs back-to-back single transfers, each separated by the release gap of R6.
- R9: A write with en_wdata=0 drops a held request (bus_req=0 on the next cycle) and closes acceptance. A transfer already in progress keeps ack_n low until its xfer_done, and no further transfer follows.
- R10: busy is 1 whenever a request is held, a transfer is running or the release gap is counting, and 0 in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_wr | input | 1 | Write strobe for the channel enable bit |
| en_wdata | input | 1 | Enable value written when en_wr is 1 |
| req_n | input | 1 | Transfer request from the device, active low level |
| bus_brk | input | 1 | Bus break: the bus is handed to this channel |
| xfer_done | input | 1 | Single transfer cycle finishes in this cycle |
| bus_req | output | 1 | Bus request while a request is held |
| ack_n | output | 1 | Acknowledge strobe to the device, active low, during the transfer |
| busy | output | 1 | Channel is not idle |

## Verification
The controller is driven with single one-cycle request pulses and with a request held low for many transfers, so that a single serve can be told apart from back-to-back serving and the release gap can be measured. Pulses placed inside a transfer and pulses placed just after its end separate the closed acceptance window from the reopened one. A low pin before and during the enabling write, and disabling writes placed both while a request is held and during a transfer, show whether sampling begins on the right edge and whether a running transfer survives the disable. A scoreboard compares the length of each acknowledge pulse with the length the bus model was told to use, and counts any extra or missing transfer.

// File: rtl/dla_pkg.sv
package dla_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_HELD,
        ST_BUS_RELEASE_WAIT,
        ST_TRANSFER,
        ST_RESUME
    } dla_state_e;

    typedef struct packed {
        dla_state_e state;
        logic       pend;
    } dla_fsm_t;
endpackage

// File: rtl/dla_enable_reg.sv
module dla_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    output logic en_q,
    output logic dis_now
);
    logic en_d;

    always_comb begin
        en_d = en_q;
        if (en_wr) begin
            en_d = en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    // a disabling write takes effect in its own cycle
    assign dis_now = en_wr && !en_wdata;
endmodule

// File: rtl/dla_gap_timer.sv
module dla_gap_timer #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CW = $clog2(MIN_GAP + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(MIN_GAP);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_level_accept.sv
module dma_level_accept #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic req_n,
    input  logic bus_brk,
    input  logic xfer_done,
    output logic bus_req,
    output logic ack_n,
    output logic busy
);
    import dla_pkg::*;

    localparam int GW = $clog2(MIN_GAP + 1);

    logic     en_q, dis_now, gap_start, gap_last, accept;
    dla_fsm_t fsm_d, fsm_q;

    dla_enable_reg u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .en_q     (en_q),
        .dis_now  (dis_now)
    );

    dla_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (gap_start),
        .last  (gap_last)
    );

    // sampling window: idle, release gap and resume
    always_comb begin
        accept = 1'b0;
        if (en_q && !dis_now) begin
            accept = (fsm_q.state == ST_IDLE) ||
                     (fsm_q.state == ST_BUS_RELEASE_WAIT) ||
                     (fsm_q.state == ST_RESUME);
        end
    end

    always_comb begin
        fsm_d     = fsm_q;
        gap_start = 1'b0;
        case (fsm_q.state)
            ST_IDLE: begin
                fsm_d.pend = 1'b0;
                if (accept && !req_n) begin
                    fsm_d.state = ST_REQ_HELD;
                end
            end
            ST_REQ_HELD: begin
                if (dis_now) begin
                    fsm_d.state = ST_IDLE;
                end else if (bus_brk) begin
                    fsm_d.state = ST_TRANSFER;
                end
            end
            ST_TRANSFER: begin
                fsm_d.pend = 1'b0;
                if (xfer_done) begin
                    fsm_d.state = ST_BUS_RELEASE_WAIT;
                    gap_start   = 1'b1;
                end
            end
            ST_BUS_RELEASE_WAIT: begin
                if (dis_now) begin
                    fsm_d.pend = 1'b0;
                end else if (accept && !req_n) begin
                    fsm_d.pend = 1'b1;
                end
                if (gap_last) begin
                    fsm_d.state = ST_RESUME;
                end
            end
            ST_RESUME: begin
                fsm_d.pend = 1'b0;
                if (!dis_now && (fsm_q.pend || (accept && !req_n))) begin
                    fsm_d.state = ST_REQ_HELD;
                end else begin
                    fsm_d.state = ST_IDLE;
                end
            end
            default: begin
                fsm_d.state = ST_IDLE;
                fsm_d.pend  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_IDLE;
            fsm_q.pend  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign bus_req = (fsm_q.state == ST_REQ_HELD);
    assign ack_n   = (fsm_q.state != ST_TRANSFER);
    assign busy    = (fsm_q.state != ST_IDLE);

    // cycles since the last acknowledge, saturating, for the gap check
    logic [GW-1:0] since_ack_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ack_q <= GW'(MIN_GAP);
        end else if (!ack_n) begin
            since_ack_q <= '0;
        end else if (since_ack_q < GW'(MIN_GAP)) begin
            since_ack_q <= since_ack_q + 1'b1;
        end
    end

    a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_brk && !(en_wr && !en_wdata)) |=> bus_req);

    a_r4_ack_after_break: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(bus_brk && bus_req));

    a_r4_ack_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !xfer_done) |=> !ack_n);

    a_r4_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && xfer_done) |=> ack_n);

    a_r6_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (since_ack_q >= GW'(MIN_GAP)));

    a_r9_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_wdata) |=> !bus_req);

    a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || !ack_n) |-> busy);
endmodule

// File: tb/tb_dma_level_accept.sv
module tb_dma_level_accept;
    localparam int MIN_GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_wr = 1'b0, en_wdata = 1'b0, req_n = 1'b1;
    logic bus_brk = 1'b0, xfer_done = 1'b0;
    logic bus_req, ack_n, busy;

    int checks = 0, errors = 0;
    int xlen = 3;
    bit bus_en = 1'b0;
    int acnt = 0;
    int plen = 0, gap = 0, pulses = 0;
    logic prev_req = 1'b0;
    int exp_q[$];

    always #10 clk = ~clk;

    dma_level_accept #(.MIN_GAP(MIN_GAP)) dut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .req_n(req_n), .bus_brk(bus_brk), .xfer_done(xfer_done),
        .bus_req(bus_req), .ack_n(ack_n), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic write_en(input logic v);
        en_wr = 1'b1; en_wdata = v;
        step();
        en_wr = 1'b0;
    endtask

    task automatic pulse_req();
        req_n = 1'b0;
        step();
        req_n = 1'b1;
    endtask

    // bus model: grants on request, finishes after xlen acknowledge cycles
    always @(negedge clk) begin
        bus_brk <= bus_en && bus_req;
        if (!ack_n) begin
            acnt = acnt + 1;
            xfer_done <= (acnt == xlen);
        end else begin
            acnt = 0;
            xfer_done <= 1'b0;
        end
    end

    // monitor and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ack_n) begin
                plen = plen + 1;
                gap  = 0;
            end else begin
                if (plen > 0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected transfer", plen, 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(plen == e, "R4 ack pulse length", plen, e);
                    end
                    pulses = pulses + 1;
                    plen = 0;
                end
                if (!bus_req) gap = gap + 1;
            end
            if (bus_req && !prev_req && pulses > 0) begin
                chk(gap >= MIN_GAP, "R6 release gap", gap, MIN_GAP);
            end
            prev_req = bus_req;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        step(3);
        // R1 reset state
        chk(ack_n == 1'b1, "R1 ack_n", ack_n, 1);
        chk(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        rst_n = 1'b1;
        step(2);

        // R2: low pin while disabled is ignored; first sample after the write
        req_n = 1'b0;
        step(3);
        chk(bus_req == 1'b0, "R2 disabled ignore", bus_req, 0);
        write_en(1'b1);
        chk(bus_req == 1'b0, "R2 write edge not sampled", bus_req, 0);
        step();
        chk(bus_req == 1'b1, "R3 request held", bus_req, 1);
        chk(busy == 1'b1, "R10 busy when held", busy, 1);
        step(2);
        chk(bus_req == 1'b1, "R3 held without break", bus_req, 1);

        // R9: disable drops held request and closes acceptance
        write_en(1'b0);
        chk(bus_req == 1'b0, "R9 disable drops", bus_req, 0);
        chk(busy == 1'b0, "R9 busy after disable", busy, 0);
        step(3);
        chk(bus_req == 1'b0, "R9 closed", bus_req, 0);
        req_n = 1'b1;
        write_en(1'b1);

        // R4 single transfer
        bus_en = 1'b1; xlen = 3;
        exp_q.push_back(3);
        pulse_req();
        while (pulses != 1) step();
        chk(busy == 1'b1, "R10 busy in gap", busy, 1);
        step(10);
        chk(pulses == 1, "R3 single serve", pulses, 1);
        chk(busy == 1'b0, "R10 idle", busy, 0);

        // R5: pulse inside the transfer is ignored
        xlen = 6;
        exp_q.push_back(6);
        pulse_req();
        while (ack_n != 1'b0) step();
        step(2);
        pulse_req();
        while (pulses != 2) step();
        step(10);
        chk(pulses == 2, "R5 ignored during transfer", pulses, 2);
        chk(bus_req == 1'b0, "R5 no request", bus_req, 0);

        // R7: pulse in the gap is held and served after it
        xlen = 2;
        exp_q.push_back(2);
        exp_q.push_back(2);
        pulse_req();
        while (pulses != 3) step();
        pulse_req();
        while (pulses != 4) step();
        step(10);
        chk(pulses == 4, "R7 gap request served", pulses, 4);

        // R8: continuous low gives back-to-back transfers
        xlen = 1;
        for (int i = 0; i < 4; i++) exp_q.push_back(1);
        req_n = 1'b0;
        while (pulses != 8) step();
        req_n = 1'b1;
        step(10);
        chk(pulses == 8, "R8 back-to-back count", pulses, 8);
        chk(bus_req == 1'b0, "R8 stops", bus_req, 0);

        // R9: disable during a transfer lets it finish
        xlen = 4;
        exp_q.push_back(4);
        req_n = 1'b0;
        while (ack_n != 1'b0) step();
        write_en(1'b0);
        while (pulses != 9) step();
        step(10);
        chk(pulses == 9, "R9 transfer finishes, none follows", pulses, 9);
        chk(busy == 1'b0, "R9 idle after", busy, 0);
        chk(exp_q.size() == 0, "R4 all transfers seen", exp_q.size(), 0);
        req_n = 1'b1;

        finish_run();
    end
endmodule